// File: doc/BRIEF.md
# Threshold Motion Interrupt Generator

This block watches a stream of signed 8-bit acceleration samples for three axes and raises an interrupt when the magnitude on any enabled axis stays above a programmable threshold for long enough. Each sample arrives with a one-cycle valid strobe. A persistence counter qualifies the event. The counter counts qualifying samples. One bit of the threshold register picks what the counter does when a sample fails to qualify: it either clears at once or drops by one.

Software sets up the block through a small register port that has a write strobe, a read strobe and a 3-bit address. It reads back a source register, which records which axes triggered the event. Reading the source register acknowledges the interrupt. A status register reports new-data and overrun flags for each axis. Reading an axis data register consumes that axis's sample. Filtering of the raw samples and the serial bus are left to neighbouring blocks.

Top module: `motion_irq_gen`

## Requirements
- R1: Three read/write registers come out of reset as zero. The enable register at address 0 holds the X, Y and Z enables in bits 0, 1 and 2 and reads back zero above them. The threshold register at address 1 holds the level in bits 6:0 and the counter mode in bit 7. The duration register at address 2 is 8 bits. A write takes effect from the next cycle.
- R2: On a cycle with `smp_valid` high, an axis hits when its enable bit is set and its magnitude is strictly greater than the 7-bit level. The magnitude of -128 is taken as 128.
- R3: An axis whose enable bit is clear never contributes to an event. With all three enables clear, `irq_o` never rises.
- R4: The hits of the three axes are OR-combined. Every valid sample with at least one hit raises the persistence counter by one, and the counter saturates at 255. Cycles without `smp_valid` change neither the counter nor the flags.
- R5: With threshold bit 7 at 0, a valid sample that does not hit clears the counter to zero.
- R6: With threshold bit 7 at 1, a valid sample that does not hit lowers the counter by one, and the counter stops at zero.
- R7: An event fires on a hitting sample whose counter value, before the increment, is at least the duration. A duration of 0 therefore fires on the first hitting sample. `irq_o` is high from the clock edge that takes the sample.
- R8: The source register at address 3 shows the active flag in bit 6 and the triggering axes in bits 2:0, with X in bit 0. Axis bits accumulate across events. A read of address 3 clears the register and drops `irq_o`, except when an event fires in the same cycle. In that case the register holds only that event's axes and `irq_o` stays high.
- R9: The status register at address 4 holds new-data flags for X, Y and Z in bits 2:0 and their OR in bit 3. It holds overrun flags for X, Y and Z in bits 6:4 and their OR in bit 7. A valid sample that arrives while an axis's new-data flag is still set sets that axis's overrun flag.
- R10: Addresses 5, 6 and 7 return the latest X, Y and Z sample. A read of one of them clears that axis's new-data and overrun flags. If a new sample arrives in the same cycle as the read, the new-data flag stays set and no overrun is recorded.
- R11: After reset, `irq_o` is low and every address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe for a new sample on all three axes |
| smp_x | input | 8 | X sample, two's complement |
| smp_y | input | 8 | Y sample, two's complement |
| smp_z | input | 8 | Z sample, two's complement |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational from state |
| irq_o | output | 1 | Interrupt line |

## Verification
Two pairs of actions can land in one cycle and pull a flag in opposite directions. A read of the source register can coincide with a sample that fires an event. A read of an axis data register can coincide with a new valid sample on that axis. The bench sets up both pairs on purpose: it issues the read strobe together with `smp_valid` on a sample that qualifies, and again on one that supplies fresh data. A behavioural model applies the read first and the set second, and the bench compares the interrupt line and the read data with that model on every cycle that follows.

// File: rtl/mig_pkg.sv
package mig_pkg;
    localparam int AXES   = 3;
    localparam int SMP_W  = 8;
    localparam int THR_W  = 7;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int REG_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE   = 3'd0,
        A_THRESH   = 3'd1,
        A_DURATION = 3'd2,
        A_SOURCE   = 3'd3,
        A_STATUS   = 3'd4,
        A_DATA_X   = 3'd5,
        A_DATA_Y   = 3'd6,
        A_DATA_Z   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             decay;
        logic [THR_W-1:0] level;
    } thresh_t;

    typedef struct packed {
        logic            active;
        logic [AXES-1:0] axes;
    } source_t;

    // Unsigned magnitude of a two's-complement sample; -128 maps to 128.
    function automatic logic [SMP_W-1:0] magnitude(input logic [SMP_W-1:0] v);
        magnitude = v[SMP_W-1] ? (~v + 1'b1) : v;
    endfunction
endpackage

// File: rtl/mig_axis_cmp.sv
module mig_axis_cmp
    import mig_pkg::*;
#(
    parameter int W  = SMP_W,
    parameter int TW = THR_W
) (
    input  logic [W-1:0]  sample,
    input  logic [TW-1:0] level,
    input  logic          enable,
    output logic          hit
);
    localparam int PAD = W - TW;

    logic [W-1:0] mag;

    always_comb begin
        mag = magnitude(sample);
        hit = enable && (mag > {{PAD{1'b0}}, level});
    end
endmodule

// File: rtl/mig_persist.sv
module mig_persist #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          qualify,
    input  logic          decay,
    input  logic [CW-1:0] limit,
    output logic          fire,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    assign fire = step && qualify && (count >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (step) begin
            if (qualify) begin
                if (count != TOP) count <= count + 1'b1;
            end else if (decay) begin
                if (count != '0) count <= count - 1'b1;
            end else begin
                count <= '0;
            end
        end
    end
endmodule

// File: rtl/mig_sample_track.sv
module mig_sample_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         consume,
    output logic [W-1:0] dout,
    output logic         fresh,
    output logic         overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            fresh   <= 1'b0;
            overrun <= 1'b0;
        end else if (load) begin
            dout  <= din;
            fresh <= 1'b1;
            if (fresh && !consume) overrun <= 1'b1;
            else if (consume)      overrun <= 1'b0;
        end else if (consume) begin
            fresh   <= 1'b0;
            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/motion_irq_gen.sv
module motion_irq_gen
    import mig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic signed [7:0] smp_x,
    input  logic signed [7:0] smp_y,
    input  logic signed [7:0] smp_z,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_o
);
    localparam int ACT_BIT  = 6;
    localparam int NEW_ANY  = AXES;
    localparam int OVR_LSB  = AXES + 1;
    localparam int OVR_ANY  = REG_W - 1;

    logic [AXES-1:0]  en_q;
    thresh_t          thr_q;
    logic [CNT_W-1:0] dur_q;
    source_t          src_q, src_d;

    logic [SMP_W-1:0] smp_arr  [AXES];
    logic [SMP_W-1:0] data_arr [AXES];
    logic [AXES-1:0]  hits, fresh, ovr, consume;
    logic             hit_any, fire, src_clear;
    logic [CNT_W-1:0] dur_cnt;

    assign smp_arr[0] = smp_x;
    assign smp_arr[1] = smp_y;
    assign smp_arr[2] = smp_z;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        mig_axis_cmp #(.W(SMP_W), .TW(THR_W)) u_cmp (
            .sample (smp_arr[g]),
            .level  (thr_q.level),
            .enable (en_q[g]),
            .hit    (hits[g])
        );

        assign consume[g] = reg_rd && (reg_addr == (ADDR_W'(A_DATA_X) + ADDR_W'(g)));

        mig_sample_track #(.W(SMP_W)) u_trk (
            .clk     (clk),
            .rst     (rst),
            .load    (smp_valid),
            .din     (smp_arr[g]),
            .consume (consume[g]),
            .dout    (data_arr[g]),
            .fresh   (fresh[g]),
            .overrun (ovr[g])
        );
    end

    assign hit_any = |hits;

    mig_persist #(.CW(CNT_W)) u_persist (
        .clk     (clk),
        .rst     (rst),
        .step    (smp_valid),
        .qualify (hit_any),
        .decay   (thr_q.decay),
        .limit   (dur_q),
        .fire    (fire),
        .count   (dur_cnt)
    );

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            thr_q <= '0;
            dur_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_ENABLE:   en_q  <= reg_wdata[AXES-1:0];
                A_THRESH:   thr_q <= thresh_t'(reg_wdata);
                A_DURATION: dur_q <= reg_wdata[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // Source latch: read clears first, a firing event then sets
    assign src_clear = reg_rd && (reg_addr == A_SOURCE);

    always_comb begin
        src_d = src_clear ? source_t'('0) : src_q;
        if (fire) begin
            src_d.active = 1'b1;
            src_d.axes   = src_d.axes | hits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_d;
    end

    assign irq_o = src_q.active;

    // Read data
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENABLE:   reg_rdata[AXES-1:0] = en_q;
            A_THRESH:   reg_rdata = REG_W'(thr_q);
            A_DURATION: reg_rdata = REG_W'(dur_q);
            A_SOURCE: begin
                reg_rdata[ACT_BIT]    = src_q.active;
                reg_rdata[AXES-1:0]   = src_q.axes;
            end
            A_STATUS: begin
                reg_rdata[AXES-1:0]           = fresh;
                reg_rdata[NEW_ANY]            = |fresh;
                reg_rdata[OVR_LSB+:AXES]      = ovr;
                reg_rdata[OVR_ANY]            = |ovr;
            end
            A_DATA_X:   reg_rdata = data_arr[0];
            A_DATA_Y:   reg_rdata = data_arr[1];
            A_DATA_Z:   reg_rdata = data_arr[2];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mig_checker.sv
module mig_checker (
    input logic       clk,
    input logic       rst,
    input logic       smp_valid,
    input logic       reg_rd,
    input logic [2:0] reg_addr,
    input logic       irq_o,
    input logic       hit_any,
    input logic [2:0] en,
    input logic [7:0] dur,
    input logic       decay,
    input logic [7:0] cnt,
    input logic [2:0] fresh,
    input logic [2:0] ovr
);
    assert_no_irq_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && en == 3'b000) |=> !irq_o);

    assert_clear_mode_R5: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !hit_any && !decay) |=> (cnt == 8'd0));

    assert_decay_mode_R6: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !hit_any && decay) |=>
            (cnt == (($past(cnt) == 8'd0) ? 8'd0 : ($past(cnt) - 8'd1))));

    assert_zero_duration_R7: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && hit_any && dur == 8'd0) |=> irq_o);

    assert_ack_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd3 && !smp_valid) |=> !irq_o);

    for (genvar g = 0; g < 3; g++) begin : g_ovr
        assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
            (smp_valid && fresh[g] && !(reg_rd && reg_addr == (3'd5 + 3'(g)))) |=> ovr[g]);
    end
endmodule

bind motion_irq_gen mig_checker u_mig_checker (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .irq_o     (irq_o),
    .hit_any   (hit_any),
    .en        (en_q),
    .dur       (dur_q),
    .decay     (thr_q.decay),
    .cnt       (dur_cnt),
    .fresh     (fresh),
    .ovr       (ovr)
);

// File: tb/motion_irq_gen_tb_top.sv
module motion_irq_gen_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              smp_valid;
    logic signed [7:0] smp_x, smp_y, smp_z;
    logic              reg_wr, reg_rd;
    logic [2:0]        reg_addr;
    logic [7:0]        reg_wdata;
    logic [7:0]        reg_rdata;
    logic              irq_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R11";

    // reference model state
    logic [2:0]        m_en;
    logic [7:0]        m_thr;
    int                m_dur;
    int                m_cnt;
    logic [2:0]        m_src;
    logic              m_ia;
    logic [2:0]        m_new, m_ovr;
    logic signed [7:0] m_data [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    motion_irq_gen dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic void model_reset();
        m_en = '0; m_thr = '0; m_dur = 0; m_cnt = 0;
        m_src = '0; m_ia = 1'b0; m_new = '0; m_ovr = '0;
        for (int i = 0; i < 3; i++) m_data[i] = '0;
    endfunction

    function automatic int mag(input logic signed [7:0] s);
        return (s < 0) ? -int'(s) : int'(s);
    endfunction

    function automatic logic [7:0] model_rdata(input logic [2:0] a);
        logic [7:0] r;
        r = '0;
        case (a)
            3'd0: r[2:0] = m_en;
            3'd1: r = m_thr;
            3'd2: r = 8'(m_dur);
            3'd3: begin r[6] = m_ia; r[2:0] = m_src; end
            3'd4: begin r[2:0] = m_new; r[3] = |m_new; r[6:4] = m_ovr; r[7] = |m_ovr; end
            default: r = m_data[a - 3'd5];
        endcase
        return r;
    endfunction

    function automatic void model_update(input logic wr, input logic rd, input logic [2:0] a,
                                         input logic [7:0] wd, input logic v,
                                         input logic signed [7:0] sx, input logic signed [7:0] sy,
                                         input logic signed [7:0] sz);
        logic signed [7:0] sv [3];
        logic [2:0] hits;
        logic fire, clr;
        sv[0] = sx; sv[1] = sy; sv[2] = sz;
        for (int i = 0; i < 3; i++)
            hits[i] = v && m_en[i] && (mag(sv[i]) > int'(m_thr[6:0]));
        fire = (hits != 3'b000) && (m_cnt >= m_dur);
        if (v) begin
            if (hits != 3'b000) m_cnt = (m_cnt < 255) ? m_cnt + 1 : 255;
            else if (m_thr[7])  m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            else                m_cnt = 0;
        end
        clr = rd && (a == 3'd3);
        if (clr) begin m_src = '0; m_ia = 1'b0; end
        if (fire) begin m_src = m_src | hits; m_ia = 1'b1; end
        for (int i = 0; i < 3; i++) begin
            logic cons;
            cons = rd && (a == 3'(5 + i));
            if (v) begin
                if (m_new[i] && !cons) m_ovr[i] = 1'b1;
                else if (cons)         m_ovr[i] = 1'b0;
                m_new[i]  = 1'b1;
                m_data[i] = sv[i];
            end else if (cons) begin
                m_new[i] = 1'b0;
                m_ovr[i] = 1'b0;
            end
        end
        if (wr) begin
            case (a)
                3'd0: m_en  = wd[2:0];
                3'd1: m_thr = wd;
                3'd2: m_dur = int'(wd);
                default: ;
            endcase
        end
    endfunction

    task automatic check_now();
        logic [7:0] exp_rd;
        exp_rd = model_rdata(reg_addr);
        n_tests++;
        if (irq_o !== m_ia) begin
            n_fail++;
            $display("FAIL %s irq_o actual=%0b expected=%0b t=%0t", cur_req, irq_o, m_ia, $time);
        end
        n_tests++;
        if (reg_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s rdata[addr %0d] actual=%02h expected=%02h t=%0t",
                     cur_req, reg_addr, reg_rdata, exp_rd, $time);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] wd,
                        input logic v, input int x, input int y, input int z);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        smp_valid = v; smp_x = 8'(x); smp_y = 8'(y); smp_z = 8'(z);
        #1;
        check_now();
        @(posedge clk);
        model_update(wr, rd, a, wd, v, 8'(x), 8'(y), 8'(z));
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, 0, 0, 0);
    endtask
    task automatic rd_reg(input logic [2:0] a);
        step(1'b0, 1'b1, a, 8'h00, 1'b0, 0, 0, 0);
    endtask
    task automatic look(input logic [2:0] a);
        step(1'b0, 1'b0, a, 8'h00, 1'b0, 0, 0, 0);
    endtask
    task automatic smp(input int x, input int y, input int z);
        step(1'b0, 1'b0, 3'd3, 8'h00, 1'b1, x, y, z);
    endtask
    task automatic clean();
        rd_reg(3'd3); rd_reg(3'd5); rd_reg(3'd6); rd_reg(3'd7);
    endtask

    initial begin
        rst = 1'b1; smp_valid = 0; smp_x = 0; smp_y = 0; smp_z = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state on every address
        cur_req = "R11";
        for (int a = 0; a < 8; a++) look(3'(a));

        // R1: configuration read-back
        cur_req = "R1";
        wr_reg(3'd0, 8'hFF); look(3'd0);
        wr_reg(3'd1, 8'hA5); look(3'd1);
        wr_reg(3'd2, 8'h3C); look(3'd2);
        wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'h00); wr_reg(3'd2, 8'h00);

        // R2: strict compare, both signs, -128
        cur_req = "R2";
        wr_reg(3'd0, 8'h01); wr_reg(3'd1, 8'd20);
        smp(20, 0, 0); look(3'd3);
        smp(-20, 0, 0); look(3'd3);
        smp(21, 0, 0); look(3'd3); clean();
        smp(-21, 0, 0); look(3'd3); clean();
        wr_reg(3'd1, 8'd127);
        smp(127, 0, 0); look(3'd3);
        smp(-128, 0, 0); look(3'd3); clean();

        // R3: disabled axes ignored
        cur_req = "R3";
        wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'd5);
        smp(100, -100, 90); smp(-128, 127, -128); look(3'd3); clean();
        wr_reg(3'd0, 8'h02);
        smp(100, 0, -100); look(3'd3);
        smp(0, -6, 0); look(3'd3); clean();

        // R4: OR-combine, accumulation, no effect without valid
        cur_req = "R4";
        wr_reg(3'd0, 8'h07); wr_reg(3'd1, 8'd10);
        smp(0, 50, 0); look(3'd3);
        smp(0, 0, -50); look(3'd3);
        step(1'b0, 1'b0, 3'd4, 8'h00, 1'b0, 90, 90, 90); look(3'd3); clean();
        wr_reg(3'd2, 8'd3);
        step(1'b0, 1'b0, 3'd3, 8'h00, 1'b0, 90, 0, 0);
        smp(90, 0, 0); smp(90, 0, 0); smp(90, 0, 0); look(3'd3);
        smp(90, 0, 0); look(3'd3); clean();

        // R5: clear mode resets persistence
        cur_req = "R5";
        wr_reg(3'd1, 8'd10); wr_reg(3'd2, 8'd3);
        smp(0, 0, 0);
        smp(40, 0, 0); smp(40, 0, 0); smp(40, 0, 0); smp(0, 0, 0);
        smp(40, 0, 0); smp(40, 0, 0); smp(40, 0, 0); look(3'd3);
        smp(40, 0, 0); look(3'd3); clean();

        // R6: decay mode decrements
        cur_req = "R6";
        wr_reg(3'd1, 8'h8A); smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0);
        smp(40, 0, 0); smp(40, 0, 0); smp(40, 0, 0); smp(0, 0, 0);
        smp(40, 0, 0); look(3'd3);
        smp(40, 0, 0); look(3'd3); clean();
        smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0);
        smp(40, 0, 0); look(3'd3); clean();

        // R7: duration 0 and a longer duration
        cur_req = "R7";
        wr_reg(3'd1, 8'd10); wr_reg(3'd2, 8'd0); smp(0, 0, 0);
        smp(0, 30, 0); look(3'd3); clean();
        wr_reg(3'd2, 8'd6); smp(0, 0, 0);
        for (int i = 0; i < 6; i++) smp(0, 0, 30);
        look(3'd3);
        smp(0, 0, 30); look(3'd3); clean();

        // R8: source read colliding with a firing sample
        cur_req = "R8";
        wr_reg(3'd2, 8'd0); smp(0, 0, 0);
        smp(50, 0, 0); look(3'd3);
        step(1'b0, 1'b1, 3'd3, 8'h00, 1'b1, 0, 50, 0); look(3'd3);
        rd_reg(3'd3); look(3'd3);
        step(1'b0, 1'b1, 3'd3, 8'h00, 1'b1, 0, 0, 0); look(3'd3); clean();

        // R9: overrun flags
        cur_req = "R9";
        wr_reg(3'd0, 8'h00);
        smp(1, 2, 3); look(3'd4);
        smp(4, 5, 6); look(3'd4);

        // R10: data read clears flags; read with simultaneous sample
        cur_req = "R10";
        rd_reg(3'd5); look(3'd4); look(3'd6);
        rd_reg(3'd6); look(3'd4);
        step(1'b0, 1'b1, 3'd7, 8'h00, 1'b1, -7, 8, -9); look(3'd4); look(3'd7);
        rd_reg(3'd7); look(3'd4); look(3'd5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule